// File: doc/BRIEF.md
# Boot Strap Mode Latch with Shared Interrupt Pin

This block captures a 2-bit operating mode from two strap pins at the moment reset is released. The captured value sits in a mode register that software can overwrite later. The second strap pin has a second job. After reset release a fixed number of clock cycles must pass. Once that count ends, the pin acts as an active-low external interrupt request.

The interrupt request is asynchronous to the clock, so it passes through a two-flop synchronizer. A trigger bit selects between two ways of reporting it:

- **Level-sensitive:** the pending flag follows the low level of the pin.
- **Falling-edge:** a high-to-low transition sets a sticky pending flag, and the flag stays set until it is cleared.

The block also holds the reset synchronizer. The external reset is active low. It asserts the internal reset at once and releases it only on a clock edge. All other state is reset synchronously from that internal signal.

A single control write port loads the mode and the trigger bit together. The word is laid out as follows:

- bit 2 selects the trigger (1 = falling edge, 0 = level).
- bits 1:0 give the mode.

Top module: `boot_strap_irq`

## Requirements
- R1: Whenever `rst_n` is low, `irq_pending` reads 0 from the first clock edge onward.
- R2: After `rst_n` rises, `op_mode` holds {`strap_b_irq_n`, `strap_a`}. These are the levels the pins had while reset was being released, with `strap_b_irq_n` as bit 1. The value stays unchanged while the pins later move.
- R3: Outside reset and without a control write, `op_mode` does not change.
- R4: A control write (`cfg_we` high for one clock) outside reset loads `op_mode` from `cfg_wdata[1:0]` and `edge_trig` from `cfg_wdata[2]`. A control write while `rst_n` is low has no effect.
- R5: For the first `SWITCH_DELAY` clock cycles after internal reset release (16 by default), activity on `strap_b_irq_n` is ignored. This covers both a held low level and a falling edge: `irq_pending` stays 0.
- R6: When `edge_trig` is 0 and the delay has passed, `irq_pending` is 1 while `strap_b_irq_n` is low and 0 while it is high. The level is seen at the output within three clock cycles. Pulsing `irq_clr` does not change `irq_pending`.
- R7: When `edge_trig` is 1 and the delay has passed, a high-to-low transition of `strap_b_irq_n` sets `irq_pending` within four clock cycles. The flag stays set after the pin returns high, and a one-cycle `irq_clr` pulse clears it. A low-to-high transition does not set it.
- R8: Reset puts `edge_trig` to 0 (level-sensitive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_a | input | 1 | Mode strap, bit 0 |
| strap_b_irq_n | input | 1 | Mode strap bit 1 during reset, then active-low interrupt request |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 3 | Control word: bit 2 trigger select, bits 1:0 mode |
| irq_clr | input | 1 | Clears a latched edge interrupt |
| op_mode | output | 2 | Current operating mode |
| edge_trig | output | 1 | Current trigger select (1 = falling edge) |
| irq_pending | output | 1 | Interrupt pending |

## Verification
The hardest case to reach from the ports is interrupt activity that falls inside the changeover window. The strap is then no longer a mode input, but it is not yet an interrupt input either.

The stimulus reaches this window in two ways:

- It releases reset with the shared pin already low in level mode, and shows that the flag stays 0 early in the window but rises once the window ends.
- It switches to edge mode by a control write just after release, then drops and raises the pin inside the window. Long after the window has closed, the flag must still be 0.

Writes issued while `rst_n` is held low are also exercised. Their lack of effect is observed through `op_mode` and `edge_trig` after release.

// File: rtl/boot_strap_pkg.sv
package boot_strap_pkg;

    typedef logic [1:0] op_mode_t;

    typedef struct packed {
        logic     edge_sel;
        op_mode_t mode;
    } ctrl_word_t;

    localparam int CTRL_W = $bits(ctrl_word_t);

    function automatic op_mode_t strap_to_mode(input logic bit_b, input logic bit_a);
        return {bit_b, bit_a};
    endfunction

endpackage

// File: rtl/bs_reset_sync.sv
module bs_reset_sync (
    input  logic clk,
    input  logic rst_n,
    output logic rst_int
);
    logic [1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 2'b00;
        else        stage_q <= {stage_q[0], 1'b1};
    end

    assign rst_int = ~stage_q[1];

    // R1: internal reset active whenever the pin is held low
    assert_rst_follow_R1: assert property (@(posedge clk) !rst_n |-> rst_int);
endmodule

// File: rtl/bs_pin_sync.sv
module bs_pin_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        meta_q <= pin_async;
        sync_q <= meta_q;
    end

    assign pin_sync = sync_q;
endmodule

// File: rtl/bs_mode_reg.sv
module bs_mode_reg
    import boot_strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_int,
    input  op_mode_t   strap_mode,
    input  logic       wr_en,
    input  ctrl_word_t wr_word,
    output op_mode_t   mode,
    output logic       edge_sel
);
    op_mode_t mode_q;
    logic     edge_q;

    always_ff @(posedge clk) begin
        if (rst_int) begin
            mode_q <= strap_mode;
            edge_q <= 1'b0;
        end else if (wr_en) begin
            mode_q <= wr_word.mode;
            edge_q <= wr_word.edge_sel;
        end
    end

    assign mode     = mode_q;
    assign edge_sel = edge_q;

    // R3: mode holds without a write once out of reset
    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (rst_int)
        !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/bs_irq_unit.sv
module bs_irq_unit #(
    parameter int SWITCH_DELAY = 16
) (
    input  logic clk,
    input  logic rst_int,
    input  logic irq_n_sync,
    input  logic edge_sel,
    input  logic clr,
    output logic pending
);
    localparam int CW = (SWITCH_DELAY < 2) ? 1 : $clog2(SWITCH_DELAY);

    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          prev_q;
    logic          latch_q;
    logic          fall;

    always_ff @(posedge clk) begin
        if (rst_int) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (!armed_q) begin
            cnt_q   <= cnt_q + 1'b1;
            armed_q <= (cnt_q == CW'(SWITCH_DELAY - 1));
        end
    end

    assign fall = prev_q & ~irq_n_sync;

    always_ff @(posedge clk) begin
        if (rst_int) begin
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            prev_q <= irq_n_sync;
            if (armed_q && edge_sel && fall) latch_q <= 1'b1;
            else if (clr)                    latch_q <= 1'b0;
        end
    end

    assign pending = edge_sel ? latch_q : (armed_q & ~irq_n_sync);

    // R5: nothing reported before the changeover delay ends
    assert_masked_R5: assert property (@(posedge clk) disable iff (rst_int)
        !armed_q |-> !pending);
    // R5: once armed, stays armed until reset
    assert_armed_sticky_R5: assert property (@(posedge clk) disable iff (rst_int)
        armed_q |=> armed_q);
    // R7: edge flag persists until cleared
    assert_edge_sticky_R7: assert property (@(posedge clk) disable iff (rst_int)
        (edge_sel && latch_q && !clr) |=> latch_q);
    // R1: pending low while in reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst_int) |-> !latch_q);
endmodule

// File: rtl/boot_strap_irq.sv
module boot_strap_irq
    import boot_strap_pkg::*;
#(
    parameter int SWITCH_DELAY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_a,
    input  logic              strap_b_irq_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              irq_clr,
    output logic [1:0]        op_mode,
    output logic              edge_trig,
    output logic              irq_pending
);
    logic       rst_int;
    logic [1:0] pins_sync;
    logic       edge_sel;
    op_mode_t   mode;
    ctrl_word_t wr_word;

    assign wr_word = ctrl_word_t'(cfg_wdata);

    bs_reset_sync u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_int (rst_int)
    );

    bs_pin_sync #(.WIDTH(2)) u_sync (
        .clk       (clk),
        .pin_async ({strap_b_irq_n, strap_a}),
        .pin_sync  (pins_sync)
    );

    bs_mode_reg u_mode (
        .clk        (clk),
        .rst_int    (rst_int),
        .strap_mode (strap_to_mode(pins_sync[1], pins_sync[0])),
        .wr_en      (cfg_we),
        .wr_word    (wr_word),
        .mode       (mode),
        .edge_sel   (edge_sel)
    );

    bs_irq_unit #(.SWITCH_DELAY(SWITCH_DELAY)) u_irq (
        .clk        (clk),
        .rst_int    (rst_int),
        .irq_n_sync (pins_sync[1]),
        .edge_sel   (edge_sel),
        .clr        (irq_clr),
        .pending    (irq_pending)
    );

    assign op_mode   = mode;
    assign edge_trig = edge_sel;
endmodule

// File: tb/test_boot_strap_irq.sv
module test_boot_strap_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_a = 1'b1;
    logic       strap_b_irq_n = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_wdata = 3'b000;
    logic       irq_clr = 1'b0;
    logic [1:0] op_mode;
    logic       edge_trig;
    logic       irq_pending;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    boot_strap_irq i_boot_strap_irq (
        .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b_irq_n(strap_b_irq_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .irq_clr(irq_clr),
        .op_mode(op_mode), .edge_trig(edge_trig), .irq_pending(irq_pending)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [2:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_clr;
        irq_clr = 1'b1;
        cyc(1);
        irq_clr = 1'b0;
    endtask

    // Reset with straps; a write during reset must be ignored
    task automatic t_reset(input logic a, input logic b);
        rst_n = 1'b0; strap_a = a; strap_b_irq_n = b;
        cyc(1);
        cfg_we = 1'b1; cfg_wdata = 3'b101;
        cyc(1);
        cfg_we = 1'b0;
        cyc(2);
        check("R1 pending in reset", irq_pending, 0);
        check("R8 trigger bit in reset", edge_trig, 0);
        rst_n = 1'b1;
        cyc(4);
        check("R2 strap mode", op_mode, {b, a});
        check("R4 write in reset ignored (trig)", edge_trig, 0);
    endtask

    task automatic t_level;
        t_reset(1'b1, 1'b1);
        strap_a = 1'b0;
        cyc(30);
        check("R2 mode after strap moves", op_mode, 3);
        check("R6 level idle", irq_pending, 0);
        strap_b_irq_n = 1'b0; cyc(3);
        check("R6 level low", irq_pending, 1);
        pulse_clr(); cyc(1);
        check("R6 clear no effect", irq_pending, 1);
        strap_b_irq_n = 1'b1; cyc(3);
        check("R6 level released", irq_pending, 0);
    endtask

    task automatic t_write_edge;
        write_ctrl(3'b110); cyc(1);
        check("R4 mode write", op_mode, 2);
        check("R4 trig write", edge_trig, 1);
        strap_a = 1'b1; cyc(5);
        check("R3 mode holds", op_mode, 2);
        strap_b_irq_n = 1'b0; cyc(4);
        check("R7 falling edge sets", irq_pending, 1);
        strap_b_irq_n = 1'b1; cyc(4);
        check("R7 sticky after rise", irq_pending, 1);
        pulse_clr(); cyc(1);
        check("R7 clear", irq_pending, 0);
        strap_b_irq_n = 1'b0; cyc(4);
        pulse_clr(); cyc(1);
        strap_b_irq_n = 1'b1; cyc(5);
        check("R7 rising edge ignored", irq_pending, 0);
    endtask

    task automatic t_level_masked;
        write_ctrl(3'b111);
        t_reset(1'b0, 1'b0);
        cyc(6);
        check("R5 level masked early", irq_pending, 0);
        cyc(20);
        check("R5 level after window", irq_pending, 1);
        strap_b_irq_n = 1'b1; cyc(3);
    endtask

    task automatic t_edge_masked;
        t_reset(1'b1, 1'b1);
        write_ctrl(3'b101);
        cyc(1);
        strap_b_irq_n = 1'b0; cyc(3);
        strap_b_irq_n = 1'b1; cyc(30);
        check("R5 edge in window ignored", irq_pending, 0);
        check("R4 mode after write", op_mode, 1);
    endtask

    initial begin
        cyc(3);
        t_level();
        t_write_edge();
        t_level_masked();
        t_edge_masked();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule